// File: doc/BRIEF.md
# Multi-Lane SPI ADC Receive Deserializer

This block is the receive side of an SPI controller that reads a two-channel simultaneous-sampling converter. The converter may present its results on several serial output lines. A single start request opens one frame. The block then drives chip select low, produces the serial clock, samples the input lanes on every rising clock edge and builds one word for each channel. When both words are complete it closes the frame and presents the two words together with a one-cycle valid strobe.

The lane layout is chosen per frame by a mode input, which is captured when the frame opens. In the dual-bus single-line layout, each channel has its own line and one bit of each word arrives per clock. In the dual-bus four-line layout, a group of four lines per channel carries four bits of its word per clock. In the shared-line layout, one line carries both words, alternating between them one bit at a time. The serial clock runs at the system clock divided by the even parameter `SCLK_DIV`. With the default 16-bit words, a frame takes 16, 4 or 32 serial clocks in the three layouts.

Top module: `mlrx_top`

## Requirements
- R1: While reset is low, and after it is released, `csN` is 1, `sclk` is 0, `valid` is 0 and both words are 0.
- R2: A `start` seen while `csN` is high drives `csN` low on the next cycle with `sclk` at 0. `sclk` stays low for `SCLK_DIV/2` cycles and then toggles every `SCLK_DIV/2` cycles, so its first change is a rising edge.
- R3: With `mode` = 0 (or the reserved value 3), a frame has WORD_W rising edges. Lane `sdi[0]` feeds `word0` and `sdi[1]` feeds `word1`, most significant bit first.
- R4: With `mode` = 1, a frame has WORD_W/4 rising edges. `sdi[3:0]` feeds `word0` and `sdi[7:4]` feeds `word1`, four bits per edge. The lower-numbered lane of each group carries the more significant bit (`sdi[0]` and `sdi[4]` are the MSB of each nibble), and the first nibble is the most significant.
- R5: With `mode` = 2, a frame has 2*WORD_W rising edges on `sdi[0]` alone. Edges 1, 3, 5, … feed `word0` and edges 2, 4, 6, … feed `word1`, MSB first.
- R6: `SCLK_DIV/2` cycles after the last rising edge, `sclk` falls and `csN` rises in the same cycle. `valid` is high for exactly that one cycle, and the new words appear in the same cycle.
- R7: `start` while `csN` is low has no effect, and a change of `mode` while `csN` is low does not alter the current frame.
- R8: The words hold their value between valid pulses. Lanes that the current mode does not use have no effect on the words.
- R9: `sclk` stays at 0 whenever `csN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Request to read one frame |
| mode | input | 2 | Lane layout: 0 single line per bus, 1 four lines per bus, 2 shared line, 3 as 0 |
| sdi | input | 8 | Serial data lanes from the converter |
| sclk | output | 1 | Serial clock, idle low |
| csN | output | 1 | Active-low chip select |
| valid | output | 1 | One-cycle strobe with new words |
| word0 | output | 16 | Channel 0 result |
| word1 | output | 16 | Channel 1 result |

## Verification
A wrong edge count or a bad divider count shows at the ports within the same frame: `sclk` or `csN` moves one or more cycles away from the position the cycle model predicts. A faulty steering of bits, such as a swapped lane, a reversed nibble or a wrong parity for the shared line, only shows at the valid pulse that ends the frame, where a word differs from the pattern the bench drove. A mode or start that leaks into a running frame changes the edge count, and the frame then ends early or late.

// File: rtl/mlrx_pkg.sv
package mlrx_pkg;

  typedef enum logic [1:0] {
    MODE_STRIPE = 2'd0,
    MODE_QUAD   = 2'd1,
    MODE_SHARED = 2'd2
  } laneMode_e;

  // strobes from the frame controller to the word assembler
  typedef struct packed {
    logic      clear;    // new frame: empty the shift registers
    logic      sample;   // rising serial edge: take one slice of lanes
    logic      toCh1;    // shared line: this slice belongs to channel 1
    logic      publish;  // frame done: move words to the outputs
    laneMode_e mode;     // layout captured at frame start
  } rxStrobe_t;

endpackage

// File: rtl/mlrx_ctrl.sv
module mlrx_ctrl
  import mlrx_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int LANE_GROUP = 4,
  parameter int SCLK_DIV   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] mode,
  output logic       sclk,
  output logic       csN,
  output rxStrobe_t  strb
);

  localparam int HALF     = SCLK_DIV / 2;
  localparam int DW       = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int EDGE_MAX = 2 * WORD_W;
  localparam int CW       = $clog2(EDGE_MAX + 1);

  logic          running;
  logic [DW-1:0] divCnt;
  logic [CW-1:0] edgeCnt;
  logic [CW-1:0] edgesNeeded;
  laneMode_e     modeQ;
  laneMode_e     modeIn;
  logic          sclkQ;
  logic          csNQ;
  logic          accept;
  logic          tick;

  always_comb begin
    unique case (mode)
      2'd1:    modeIn = MODE_QUAD;
      2'd2:    modeIn = MODE_SHARED;
      default: modeIn = MODE_STRIPE;
    endcase
  end

  always_comb begin
    unique case (modeQ)
      MODE_QUAD:   edgesNeeded = CW'(WORD_W / LANE_GROUP);
      MODE_SHARED: edgesNeeded = CW'(EDGE_MAX);
      default:     edgesNeeded = CW'(WORD_W);
    endcase
  end

  assign accept = !running && start;
  assign tick   = running && (divCnt == '0);

  always_comb begin
    strb.clear   = accept;
    strb.sample  = tick && !sclkQ;
    strb.toCh1   = edgeCnt[0];
    strb.publish = tick && sclkQ && (edgeCnt == edgesNeeded);
    strb.mode    = modeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
      modeQ   <= MODE_STRIPE;
      sclkQ   <= 1'b0;
      csNQ    <= 1'b1;
    end else if (accept) begin
      running <= 1'b1;
      divCnt  <= DW'(HALF - 1);
      edgeCnt <= '0;
      modeQ   <= modeIn;
      sclkQ   <= 1'b0;
      csNQ    <= 1'b0;
    end else if (running) begin
      if (divCnt != '0) begin
        divCnt <= divCnt - 1'b1;
      end else begin
        divCnt <= DW'(HALF - 1);
        if (!sclkQ) begin
          sclkQ   <= 1'b1;
          edgeCnt <= edgeCnt + 1'b1;
        end else begin
          sclkQ <= 1'b0;
          if (edgeCnt == edgesNeeded) begin
            running <= 1'b0;
            csNQ    <= 1'b1;
          end
        end
      end
    end
  end

  assign sclk = sclkQ;
  assign csN  = csNQ;

endmodule

// File: rtl/mlrx_data.sv
module mlrx_data
  import mlrx_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int LANE_GROUP = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2*LANE_GROUP-1:0] sdi,
  input  rxStrobe_t               strb,
  output logic [WORD_W-1:0]       word0,
  output logic [WORD_W-1:0]       word1,
  output logic                    valid
);

  logic [LANE_GROUP-1:0] slice [2];
  logic [WORD_W-1:0]     sh0;
  logic [WORD_W-1:0]     sh1;

  // lowest lane of each group becomes the slice MSB
  for (genvar g = 0; g < 2; g++) begin : g_bus
    for (genvar j = 0; j < LANE_GROUP; j++) begin : g_lane
      assign slice[g][LANE_GROUP-1-j] = sdi[g*LANE_GROUP+j];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sh0 <= '0;
      sh1 <= '0;
    end else if (strb.clear) begin
      sh0 <= '0;
      sh1 <= '0;
    end else if (strb.sample) begin
      unique case (strb.mode)
        MODE_QUAD: begin
          sh0 <= {sh0[WORD_W-LANE_GROUP-1:0], slice[0]};
          sh1 <= {sh1[WORD_W-LANE_GROUP-1:0], slice[1]};
        end
        MODE_SHARED: begin
          if (strb.toCh1) sh1 <= {sh1[WORD_W-2:0], sdi[0]};
          else            sh0 <= {sh0[WORD_W-2:0], sdi[0]};
        end
        default: begin
          sh0 <= {sh0[WORD_W-2:0], sdi[0]};
          sh1 <= {sh1[WORD_W-2:0], sdi[1]};
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      word0 <= '0;
      word1 <= '0;
      valid <= 1'b0;
    end else begin
      valid <= strb.publish;
      if (strb.publish) begin
        word0 <= sh0;
        word1 <= sh1;
      end
    end
  end

endmodule

// File: rtl/mlrx_top.sv
module mlrx_top
  import mlrx_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int LANE_GROUP = 4,
  parameter int SCLK_DIV   = 2,
  localparam int LANES     = 2 * LANE_GROUP
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [LANES-1:0]  sdi,
  output logic              sclk,
  output logic              csN,
  output logic              valid,
  output logic [WORD_W-1:0] word0,
  output logic [WORD_W-1:0] word1
);

  rxStrobe_t strb;

  mlrx_ctrl #(
    .WORD_W(WORD_W), .LANE_GROUP(LANE_GROUP), .SCLK_DIV(SCLK_DIV)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .sclk(sclk), .csN(csN), .strb(strb)
  );

  mlrx_data #(
    .WORD_W(WORD_W), .LANE_GROUP(LANE_GROUP)
  ) data_i (
    .clk(clk), .rstN(rstN), .sdi(sdi), .strb(strb),
    .word0(word0), .word1(word1), .valid(valid)
  );

endmodule

// File: rtl/mlrx_checker.sv
module mlrx_checker #(
  parameter int WORD_W     = 16,
  parameter int LANE_GROUP = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [1:0]        mode,
  input logic              sclk,
  input logic              csN,
  input logic              valid,
  input logic [WORD_W-1:0] word0,
  input logic [WORD_W-1:0] word1
);

  localparam int CW = $clog2(2 * WORD_W + 1);

  logic [CW-1:0] riseCnt;
  logic [1:0]    modeCap;
  logic          sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseCnt  <= '0;
      modeCap  <= 2'd0;
      sclkPrev <= 1'b0;
    end else begin
      sclkPrev <= sclk;
      if (start && csN) begin
        riseCnt <= '0;
        modeCap <= mode;
      end else if (!csN && sclk && !sclkPrev) begin
        riseCnt <= riseCnt + 1'b1;
      end
    end
  end

  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);  // R9
  AST_FRAME_OPENS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !sclk);  // R2
  AST_START_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (start && csN) |=> !csN);  // R2
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> !valid);  // R6
  AST_VALID_AT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> ($rose(csN) && !sclk));  // R6
  AST_RELEASE_HAS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> valid);  // R6
  AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> ($stable(word0) && $stable(word1)));  // R8
  AST_STRIPE_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    (valid && (modeCap == 2'd0 || modeCap == 2'd3)) |-> (riseCnt == CW'(WORD_W)));  // R3
  AST_QUAD_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    (valid && modeCap == 2'd1) |-> (riseCnt == CW'(WORD_W / LANE_GROUP)));  // R4
  AST_SHARED_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    (valid && modeCap == 2'd2) |-> (riseCnt == CW'(2 * WORD_W)));  // R5

endmodule

bind mlrx_top mlrx_checker #(.WORD_W(WORD_W), .LANE_GROUP(LANE_GROUP)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .mode(mode), .sclk(sclk),
  .csN(csN), .valid(valid), .word0(word0), .word1(word1)
);

// File: tb/mlrx_top_tb_top.sv
`timescale 1ns/1ps
module mlrx_top_tb_top;

  localparam int W    = 16;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic [7:0]   sdi = 8'h00;
  logic         sclk, csN, valid;
  logic [W-1:0] word0, word1;

  int nChecks = 0;
  int nFail = 0;

  // frame the peripheral is sending
  logic [W-1:0] tA = '0, tB = '0;
  int           txMode = 0;

  always #2.5 clk = ~clk;

  mlrx_top #(.WORD_W(W), .LANE_GROUP(4), .SCLK_DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .sdi(sdi),
    .sclk(sclk), .csN(csN), .valid(valid), .word0(word0), .word1(word1)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference state
  logic         eCs = 1'b1, eSclk = 1'b0, eValid = 1'b0;
  logic [W-1:0] eW0 = '0, eW1 = '0, acc0 = '0, acc1 = '0;
  bit           active = 0;
  int           k = 0, nEdges = 0, mMode = 0, nSampled = 0;
  logic         prevCs = 1'b1, prevSclk = 1'b0;
  int           bIdx = 0;

  function automatic int edgesFor(input int m);
    if (m == 1) return W / 4;
    if (m == 2) return 2 * W;
    return W;
  endfunction

  always @(negedge clk) begin
    logic [7:0] v;
    int idx;
    // 1: compare against the prediction for this cycle
    if (!rstN) begin
      chk("R1", "csN", csN, 1'b1);
      chk("R1", "sclk", sclk, 1'b0);
      chk("R1", "valid", valid, 1'b0);
      chk("R1", "word0", word0, '0);
      chk("R1", "word1", word1, '0);
    end else begin
      chk("R2", "csN", csN, eCs);
      chk(eCs ? "R9" : "R2", "sclk", sclk, eSclk);
      chk("R6", "valid", valid, eValid);
      chk("R8", "word0", word0, eW0);
      chk("R8", "word1", word1, eW1);
    end
    // 2: peripheral presents the next bit after csN falls or sclk falls
    v = 8'($urandom);
    if (!csN && (prevCs || (prevSclk && !sclk))) begin
      bIdx = prevCs ? 0 : bIdx + 1;
      if (txMode == 1) begin
        for (int j = 0; j < 4; j++) begin
          idx = W - 1 - 4 * bIdx - j;
          if (idx >= 0) begin
            v[j]     = tA[idx];
            v[4 + j] = tB[idx];
          end
        end
      end else if (txMode == 2) begin
        idx = W - 1 - bIdx / 2;
        if (idx >= 0) v[0] = (bIdx % 2 == 0) ? tA[idx] : tB[idx];
      end else begin
        idx = W - 1 - bIdx;
        if (idx >= 0) begin
          v[0] = tA[idx];
          v[1] = tB[idx];
        end
      end
      sdi = v;
    end else if (csN) begin
      sdi = v;
    end
    prevCs = csN;
    prevSclk = sclk;
    // 3: advance the reference to the state after the next rising clock
    if (!rstN) begin
      active = 0; eCs = 1'b1; eSclk = 1'b0; eValid = 1'b0; eW0 = '0; eW1 = '0;
    end else begin
      eValid = 1'b0;
      if (!active) begin
        if (start) begin
          active = 1; k = 0; nSampled = 0;
          mMode = (mode == 2'd1) ? 1 : (mode == 2'd2) ? 2 : 0;
          nEdges = edgesFor(mMode);
          acc0 = '0; acc1 = '0; eCs = 1'b0; eSclk = 1'b0;
        end
      end else begin
        if (((k / HALF) % 2 == 0) && (((k + 1) / HALF) % 2 == 1)) begin
          if (mMode == 1) begin
            for (int j = 0; j < 4; j++) begin
              acc0 = {acc0[W-2:0], sdi[j]};
              acc1 = {acc1[W-2:0], sdi[4 + j]};
            end
          end else if (mMode == 2) begin
            if (nSampled % 2 == 0) acc0 = {acc0[W-2:0], sdi[0]};
            else                   acc1 = {acc1[W-2:0], sdi[0]};
          end else begin
            acc0 = {acc0[W-2:0], sdi[0]};
            acc1 = {acc1[W-2:0], sdi[1]};
          end
          nSampled++;
        end
        k++;
        if (k == 2 * nEdges * HALF) begin
          active = 0; eCs = 1'b1; eSclk = 1'b0; eValid = 1'b1;
          eW0 = acc0; eW1 = acc1;
        end else begin
          eSclk = ((k / HALF) % 2 == 1);
        end
      end
    end
  end

  task automatic runTx(input int m, input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit poke, input string tag);
    int n = 0;
    @(posedge clk); #1;
    txMode = (m == 3) ? 0 : m;
    tA = a; tB = b; mode = 2'(m); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    while (!valid && n < 2000) begin
      if (poke && n == 9) begin
        start = 1'b1; mode = 2'd1;  // R7: ignored while the frame runs
      end else if (poke && n == 10) begin
        start = 1'b0;
      end
      @(posedge clk); #1;
      n++;
    end
    chk(tag, "frame word0", word0, a);
    chk(tag, "frame word1", word1, b);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (3) @(posedge clk);
    runTx(0, 16'hA5C3, 16'h5A3C, 0, "R3");
    runTx(1, 16'h1234, 16'hFEDC, 0, "R4");
    runTx(2, 16'hBEEF, 16'h0F0F, 0, "R5");
    runTx(3, 16'h8001, 16'h7FFE, 0, "R3");
    runTx(0, 16'hC0DE, 16'h1357, 1, "R7");
    runTx(1, 16'hFFFF, 16'h0000, 0, "R4");
    runTx(2, 16'h0001, 16'h8000, 0, "R5");
    runTx(1, 16'h8421, 16'h1248, 0, "R8");
    repeat (20) @(posedge clk);  // R9: idle cycles compared by the reference
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    nFail++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule